// File: doc/BRIEF.md
# Multiplexed-Bus Write Cycle Sequencer

This block produces the pin-level timing of one write machine cycle for an 8-bit processor whose low address byte shares the data lines. On an idle clock, a start request captures a 16-bit address, a data byte and a flag that picks memory write or port (I/O) write. The block then steps through three T-states, T1, T2 and T3, in that order. It drives the dedicated upper address lines, the shared address/data lines with their output enable, an address-latch strobe, three status lines, and active-low write and read strobes.

The clock runs at twice the T-state rate, so every T-state has a first half and a second half of one clock each. Strobe edges that fall in the middle of a T-state land on a clock edge. A complete cycle takes six clocks. A one-clock done pulse marks the last half of T3, and the block can take a new request on the following clock.

Top module: `wrcyc_seq`

## Requirements
- R1: A start accepted on an idle clock is followed by exactly six busy clocks: T1 first half, T1 second half, T2 first half, T2 second half, T3 first half, T3 second half. `done_o` is high only on the sixth of these clocks.
- R2: `ale_o` is high only during the first half of T1 and low on every other clock.
- R3: For a memory write, `a_hi_o` carries address bits 15..8 on all six busy clocks.
- R4: `ad_oe_o` is high on all six busy clocks. `ad_o` carries address bits 7..0 during T1 and the data byte during T2 and T3.
- R5: During a cycle the status lines are `s1_o`=0 and `s0_o`=1. `io_m_o` is 0 for a memory write and 1 for an I/O write. All three hold steady for the whole cycle.
- R6: `wr_n_o` is low from the start of T2 through the first half of T3 (busy clocks 3, 4 and 5). It is high on busy clocks 1, 2 and 6 and when idle.
- R7: `rd_n_o` is high at all times.
- R8: For an I/O write, address bits 7..0 (the port number) appear on `a_hi_o` for all six busy clocks and on `ad_o` during T1.
- R9: When idle, `ale_o`=0, `wr_n_o`=1, `rd_n_o`=1, `ad_oe_o`=0, `busy_o`=0, `done_o`=0, `io_m_o`=`s1_o`=`s0_o`=0, and both address lanes read 0.
- R10: A start request while busy, including the done clock, is ignored and the captured address, data and type are unchanged. A start held through the end of a cycle is accepted on the first idle clock.
- R11: Asserting the active-low reset `rst_n` at any time returns the block to idle (R9 outputs) with no cycle pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a write cycle (taken only when idle) |
| is_io_i | input | 1 | 1 = I/O write, 0 = memory write |
| addr_i | input | 16 | Target address (port number in bits 7..0 for I/O) |
| data_i | input | 8 | Byte to write |
| a_hi_o | output | 8 | Dedicated upper address lane |
| ad_o | output | 8 | Shared low-address / data lane |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| ale_o | output | 1 | Address latch strobe |
| io_m_o | output | 1 | Status: 1 = I/O, 0 = memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| wr_n_o | output | 1 | Active-low write strobe |
| rd_n_o | output | 1 | Active-low read strobe |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse on the last half of T3 |

## Verification
The bench samples every half-T-state of each cycle. A design that lets ALE stay high for a full T-state, drops WR' one clock early, or releases it at the end of T3 rather than its middle fails on an exact clock. Port writes check that the port number is copied onto the upper lane, which a design reusing address bits 15..8 would miss. A start held high across the done clock must be ignored there and accepted on the next clock. A design that restarts from T3 or latches new operands mid-cycle would show the wrong lane values. A reset in the middle of T2 must drop the lanes and strobes to idle at once.

// File: rtl/wrcyc_pkg.sv
package wrcyc_pkg;
    // Half-T-state phases of one write machine cycle; order is the bus sequence.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1A  = 3'd1,
        PH_T1B  = 3'd2,
        PH_T2A  = 3'd3,
        PH_T2B  = 3'd4,
        PH_T3A  = 3'd5,
        PH_T3B  = 3'd6
    } phase_e;
endpackage

// File: rtl/wrcyc_phase_seq.sv
module wrcyc_phase_seq
    import wrcyc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          is_io_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output phase_e        phase_o,
    output logic          is_io_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        phase_e        phase;
        logic          is_io;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_T1A;
                    st_d.is_io = is_io_i;
                    st_d.addr  = addr_i;
                    st_d.data  = data_i;
                end
            end
            PH_T3B:  st_d.phase = PH_IDLE;
            default: st_d.phase = phase_e'(st_q.phase + 3'd1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign is_io_o = st_q.is_io;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != PH_IDLE && start_i) |=> (phase_o != PH_T1A && $stable(addr_o) && $stable(data_o)));

    // R1
    start_enters_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_IDLE && start_i) |=> (phase_o == PH_T1A));
endmodule

// File: rtl/wrcyc_lane_drv.sv
module wrcyc_lane_drv
    import wrcyc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  phase_e         phase_i,
    input  logic           is_io_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  data_i,
    output logic [AW-DW-1:0] a_hi_o,
    output logic [DW-1:0]  ad_o,
    output logic           ad_oe_o,
    output logic           ale_o,
    output logic           io_m_o,
    output logic           s1_o,
    output logic           s0_o,
    output logic           wr_n_o,
    output logic           rd_n_o,
    output logic           busy_o,
    output logic           done_o
);
    localparam int HW = AW - DW;

    logic [HW-1:0] port_hi;
    logic          in_t1;
    logic          wr_win;

    // Port number copied onto the upper lane; width of that lane picks the variant.
    generate
        if (HW >= DW) begin : g_port_wide
            assign port_hi = HW'(addr_i[DW-1:0]);
        end else begin : g_port_narrow
            assign port_hi = addr_i[HW-1:0];
        end
    endgenerate

    always_comb begin
        busy_o  = (phase_i != PH_IDLE);
        in_t1   = (phase_i == PH_T1A) || (phase_i == PH_T1B);
        wr_win  = (phase_i == PH_T2A) || (phase_i == PH_T2B) || (phase_i == PH_T3A);
        ale_o   = (phase_i == PH_T1A);
        done_o  = (phase_i == PH_T3B);
        wr_n_o  = !wr_win;
        rd_n_o  = 1'b1;
        ad_oe_o = busy_o;
        io_m_o  = busy_o && is_io_i;
        s1_o    = 1'b0;
        s0_o    = busy_o;
        a_hi_o  = '0;
        ad_o    = '0;
        if (busy_o) begin
            a_hi_o = is_io_i ? port_hi : addr_i[AW-1:DW];
            ad_o   = in_t1 ? addr_i[DW-1:0] : data_i;
        end
    end

    // R2
    ale_half_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R6
    wr_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(ale_o, 2));

    // R6
    wr_release_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_n_o && !$past(wr_n_o)));

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(io_m_o) && $stable(a_hi_o)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ale_o && wr_n_o && !ad_oe_o && !io_m_o));
endmodule

// File: rtl/wrcyc_seq.sv
module wrcyc_seq
    import wrcyc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_io_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     data_i,
    output logic [AW-DW-1:0]  a_hi_o,
    output logic [DW-1:0]     ad_o,
    output logic              ad_oe_o,
    output logic              ale_o,
    output logic              io_m_o,
    output logic              s1_o,
    output logic              s0_o,
    output logic              wr_n_o,
    output logic              rd_n_o,
    output logic              busy_o,
    output logic              done_o
);
    phase_e        phase;
    logic          cap_io;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;

    wrcyc_phase_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .is_io_i (is_io_i),
        .addr_i  (addr_i),
        .data_i  (data_i),
        .phase_o (phase),
        .is_io_o (cap_io),
        .addr_o  (cap_addr),
        .data_o  (cap_data)
    );

    wrcyc_lane_drv #(.AW(AW), .DW(DW)) drv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .is_io_i (cap_io),
        .addr_i  (cap_addr),
        .data_i  (cap_data),
        .a_hi_o  (a_hi_o),
        .ad_o    (ad_o),
        .ad_oe_o (ad_oe_o),
        .ale_o   (ale_o),
        .io_m_o  (io_m_o),
        .s1_o    (s1_o),
        .s0_o    (s0_o),
        .wr_n_o  (wr_n_o),
        .rd_n_o  (rd_n_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );
endmodule

// File: tb/wrcyc_seq_tb.sv
module wrcyc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_io_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  a_hi_o, ad_o;
    logic        ad_oe_o, ale_o, io_m_o, s1_o, s0_o, wr_n_o, rd_n_o, busy_o, done_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wrcyc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_io_i(is_io_i),
        .addr_i(addr_i), .data_i(data_i), .a_hi_o(a_hi_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .ale_o(ale_o), .io_m_o(io_m_o), .s1_o(s1_o),
        .s0_o(s0_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o), .busy_o(busy_o),
        .done_o(done_o)
    );

    // {is_io, addr, data}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 16'h1234, 8'hA5},
        {1'b1, 16'h0023, 8'h5A},
        {1'b0, 16'hFFFF, 8'h00},
        {1'b1, 16'hBE7F, 8'hFF},
        {1'b0, 16'h0000, 8'hC3},
        {1'b1, 16'h8001, 8'h3C}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "busy", busy_o, 0);
        check(req, "ale", ale_o, 0);
        check(req, "wr_n", wr_n_o, 1);
        check("R7", "rd_n idle", rd_n_o, 1);
        check(req, "ad_oe", ad_oe_o, 0);
        check(req, "done", done_o, 0);
        check(req, "status", {io_m_o, s1_o, s0_o}, 0);
        check(req, "lanes", {a_hi_o, ad_o}, 0);
    endtask

    // Checks one busy half-T-state k (0..5) against the expected lane values.
    task automatic check_phase(input int k, input logic io, input logic [15:0] a, input logic [7:0] d);
        logic [7:0] hi_exp;
        hi_exp = io ? a[7:0] : a[15:8];
        check("R1", $sformatf("busy k=%0d", k), busy_o, 1);
        check("R1", $sformatf("done k=%0d", k), done_o, (k == 5) ? 1 : 0);
        check("R2", $sformatf("ale k=%0d", k), ale_o, (k == 0) ? 1 : 0);
        check(io ? "R8" : "R3", $sformatf("a_hi k=%0d", k), a_hi_o, hi_exp);
        check(io ? "R8" : "R4", $sformatf("ad k=%0d", k), ad_o, (k < 2) ? a[7:0] : d);
        check("R4", $sformatf("ad_oe k=%0d", k), ad_oe_o, 1);
        check("R5", $sformatf("status k=%0d", k), {io_m_o, s1_o, s0_o}, {io, 2'b01});
        check("R6", $sformatf("wr_n k=%0d", k), wr_n_o, (k >= 2 && k <= 4) ? 0 : 1);
        check("R7", $sformatf("rd_n k=%0d", k), rd_n_o, 1);
    endtask

    task automatic run_cycle(input logic io, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        start_i = 1'b1; is_io_i = io; addr_i = a; data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check_phase(k, io, a, d);
            @(negedge clk);
        end
        check_idle("R9");
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: outputs idle while in reset
        #1;
        check_idle("R11");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R9");

        for (int v = 0; v < 6; v++) begin
            run_cycle(VEC[v][24], VEC[v][23:8], VEC[v][7:0]);
        end

        // R10: start during the cycle (and held through done) is ignored until idle
        @(negedge clk);
        start_i = 1'b1; is_io_i = 1'b0; addr_i = 16'h4321; data_i = 8'h77;
        @(negedge clk);
        is_io_i = 1'b1; addr_i = 16'h99AA; data_i = 8'h11;
        for (int k = 0; k < 6; k++) begin
            check_phase(k, 1'b0, 16'h4321, 8'h77);
            @(negedge clk);
        end
        // first idle clock: start still high, so it is accepted on this edge
        check("R10", "idle between cycles", busy_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        check("R10", "held start accepted", busy_o, 1);
        check("R10", "new cycle upper lane", a_hi_o, 8'hAA);
        check("R10", "new cycle ale", ale_o, 1);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            check_phase(k, 1'b1, 16'h99AA, 8'h11);
        end
        @(negedge clk);
        check_idle("R9");

        // R11: reset in the middle of T2
        @(negedge clk);
        start_i = 1'b1; is_io_i = 1'b0; addr_i = 16'h5566; data_i = 8'h88;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R11", "pre-reset wr_n", wr_n_o, 0);
        rst_n = 1'b0;
        #1;
        check_idle("R11");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R11");

        run_cycle(1'b1, 16'h0042, 8'h24);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule